// File: doc/BRIEF.md
# Four-Level Return Address Stack

This block holds return addresses for a small processor core. It is a chain of four 12-bit registers. When a call or an interrupt saves the program counter, every stored address moves one level deeper and the new address enters at the top. When a return restores the program counter, the top address leaves and every deeper address moves up one level. The same two strobes serve the explicit save and restore operations that move the low 12 bits of an accumulator to or from the stack. The stack has no pointer and no error outputs.

The current top entry is always visible on `top_o`. The surrounding program-counter logic reads the address there in the same cycle that it raises `pop_i`. When the chain is full, a further save drops the deepest address without warning. When the chain has been drained, the bottom level copies itself upward on each pop. As a result, every pop after the third one in a row returns the deepest value.

Top module: `rstk_top`

## Requirements
- R1: A synchronous active-high reset clears all four levels to 12'h000, so `top_o` reads 12'h000 after reset, and so do the first four pops that follow.
- R2: A cycle with `push_i`=1 and `pop_i`=0 loads `push_data_i` into the top level, moves level k into level k+1 for k = 0..2, and discards the old value of the deepest level (level 3).
- R3: `top_o` always shows the top level, which is the value that a pop delivers. A cycle with `pop_i`=1 and `push_i`=0 moves level k+1 into level k for k = 0..2.
- R4: On a pop, the deepest level keeps its own value. After three consecutive pops, every further pop therefore delivers the deepest value, and all four levels hold that value.
- R5: A cycle with both `push_i`=1 and `pop_i`=1 replaces the top level with `push_data_i` and leaves levels 1..3 unchanged.
- R6: A cycle with both strobes at 0 changes no level, whatever value is on `push_data_i`.
- R7: Every level is 12 bits wide and stores all bits of `push_data_i`, from 12'h000 through 12'hFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Save strobe: push `push_data_i` |
| pop_i | input | 1 | Restore strobe: drop the top entry |
| push_data_i | input | 12 | Address to save (PC or accumulator low bits) |
| top_o | output | 12 | Current top entry, the value a pop returns |

## Verification
The bench fills the stack past four entries and checks that the oldest address never returns. A design that kept it, or that wrapped like a pointer, would bring it back. It drains the stack past empty and expects the deepest value to repeat. A design that shifted in zeros or held a stale top would show up here. Simultaneous push and pop must replace only the top. A design that treated this case as a push would bury the old entry one level down. Idle cycles with changing data, and a reset in the middle of a sequence followed by pops, confirm that nothing leaks into the stored levels.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam int unsigned RSTK_W     = 12;
    localparam int unsigned RSTK_DEPTH = 4;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_REPLACE = 2'd3
    } stk_op_e;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        stk_op_e op;
        unique case ({push, pop})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_REPLACE;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output stk_op_e op_o
);
    always_comb op_o = decode_op(push_i, pop_i);
endmodule

// File: rtl/rstk_cell.sv
module rstk_cell
    import rstk_pkg::*;
#(
    parameter int unsigned W      = RSTK_W,
    parameter bit          IS_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  stk_op_e      op_i,
    input  logic [W-1:0] above_i,
    input  logic [W-1:0] below_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            case (op_i)
                OP_PUSH:    q_o <= above_i;
                OP_POP:     q_o <= below_i;
                OP_REPLACE: if (IS_TOP) q_o <= above_i;
                default:    q_o <= q_o;
            endcase
        end
    end
endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int unsigned W     = RSTK_W,
    parameter int unsigned DEPTH = RSTK_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);
    localparam int unsigned LAST = DEPTH - 1;

    stk_op_e        op;
    logic [W-1:0]   lvl [DEPTH];
    logic [W*DEPTH-1:0] lvl_flat;

    rstk_ctrl u_ctrl (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        logic [W-1:0] above;
        logic [W-1:0] below;

        if (g == 0) begin : g_first
            assign above = push_data_i;
        end else begin : g_inner_a
            assign above = lvl[g-1];
        end

        // The deepest level feeds itself on a pop: it copies upward (R4).
        if (g == LAST) begin : g_last
            assign below = lvl[g];
        end else begin : g_inner_b
            assign below = lvl[g+1];
        end

        rstk_cell #(.W(W), .IS_TOP(g == 0)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .op_i    (op),
            .above_i (above),
            .below_i (below),
            .q_o     (lvl[g])
        );

        assign lvl_flat[g*W +: W] = lvl[g];
    end

    assign top_o = lvl[0];

endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic [W-1:0]     push_data_i,
    input logic [W-1:0]     top_o,
    input logic [W*DEPTH-1:0] lvl_flat
);
    localparam int unsigned LAST = DEPTH - 1;

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (lvl_flat == '0));

    a_r2_push_loads_top: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> (top_o == $past(push_data_i)));

    a_r5_replace_top: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> (top_o == $past(push_data_i)));

    a_r4_bottom_keeps: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> $stable(lvl_flat[LAST*W +: W]));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> $stable(lvl_flat));

    for (genvar g = 1; g < DEPTH; g++) begin : g_dn
        a_r2_push_shift: assert property (@(posedge clk) disable iff (rst)
            (push_i && !pop_i) |=> (lvl_flat[g*W +: W] == $past(lvl_flat[(g-1)*W +: W])));
        a_r5_replace_keeps: assert property (@(posedge clk) disable iff (rst)
            (push_i && pop_i) |=> $stable(lvl_flat[g*W +: W]));
    end

    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_up
        a_r3_pop_shift: assert property (@(posedge clk) disable iff (rst)
            (pop_i && !push_i) |=> (lvl_flat[g*W +: W] == $past(lvl_flat[(g+1)*W +: W])));
    end

endmodule

bind rstk_top rstk_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .top_o       (top_o),
    .lvl_flat    (lvl_flat)
);

// File: tb/rstk_top_tb.sv
module rstk_top_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NVEC = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [11:0] push_data_i = '0;
    logic [11:0] top_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstk_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .top_o       (top_o)
    );

    // {push, pop, data, expected top after the edge}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 12'h111, 12'h111},  // R2
        {1'b1, 1'b0, 12'h222, 12'h222},  // R2
        {1'b1, 1'b0, 12'h333, 12'h333},  // R2
        {1'b1, 1'b0, 12'h444, 12'h444},  // R2
        {1'b1, 1'b0, 12'h555, 12'h555},  // R2 111 dropped
        {1'b0, 1'b1, 12'h000, 12'h444},  // R3
        {1'b0, 1'b1, 12'h000, 12'h333},  // R3
        {1'b0, 1'b1, 12'h000, 12'h222},  // R3
        {1'b0, 1'b1, 12'h000, 12'h222},  // R4 / R2 lost entry never returns
        {1'b0, 1'b0, 12'hABC, 12'h222},  // R6
        {1'b1, 1'b1, 12'h7E1, 12'h7E1},  // R5
        {1'b0, 1'b1, 12'h000, 12'h222},  // R5 lower level intact
        {1'b1, 1'b0, 12'hFFF, 12'hFFF},  // R7
        {1'b1, 1'b1, 12'h001, 12'h001},  // R5 / R7
        {1'b0, 1'b1, 12'h000, 12'h222}   // R5
    };

    task automatic check(input string tag, input logic [11:0] exp);
        n_chk++;
        if (top_o !== exp) begin
            n_fail++;
            $display("FAIL %s: top_o=%h expected=%h", tag, top_o, exp);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic [11:0] d);
        push_i = p;
        pop_i = q;
        push_data_i = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset top", 12'h000);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][25], VEC[i][24], VEC[i][23:12]);
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), VEC[i][11:0]);
        end

        // R4: drain a full stack past empty
        step(1, 0, 12'hA01);
        step(1, 0, 12'hB02);
        step(1, 0, 12'hC03);
        step(1, 0, 12'hD04);
        check("R2 fill top", 12'hD04);
        step(0, 1, 12'h000); check("R3 pop 1", 12'hC03);
        step(0, 1, 12'h000); check("R3 pop 2", 12'hB02);
        step(0, 1, 12'h000); check("R4 pop 3", 12'hA01);
        step(0, 1, 12'h000); check("R4 pop 4 replicate", 12'hA01);
        step(0, 1, 12'h000); check("R4 pop 5 replicate", 12'hA01);

        // R6: idle with noisy data
        step(0, 0, 12'h5A5);
        step(0, 0, 12'hFFF);
        check("R6 idle hold", 12'hA01);

        // R1: reset in mid-run clears every level
        step(1, 0, 12'h123);
        step(1, 0, 12'h456);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run", 12'h000);
        for (int k = 0; k < 4; k++) begin
            step(0, 1, 12'h000);
            check($sformatf("R1 pop after reset %0d", k), 12'h000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: expected=done actual=hung");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule